// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block walks a ring of transmit buffer descriptors held in a small on-chip descriptor table. Software fills the table and a few control registers through a 32-bit register port. Each descriptor is a status/length word followed by a buffer pointer word. When the sequencer finds the descriptor at its current index marked ready, it passes the pointer, length and per-frame options to a transmit engine with a one-cycle start pulse. It then waits for the engine's done strobe and writes the engine's completion status back into the same status word. The write-back also clears the ready flag, so ownership returns to software. Finally it raises interrupt-source bits and advances the index.

The transmit part of the shared table covers the first entries, up to a programmable count that is limited to the table size. Entries past that count belong to receive logic and are never visited. The ring turns back to entry 0 after a descriptor with its wrap bit set, or after the last transmit entry. A mode bit enables transmission. When that bit is cleared, the frame in flight is completed and the ring index returns to 0.

Top module: `tx_desc_seq`

## Requirements
- R1: After reset the interrupt source and mask registers read 0, the mode register reads 0 (transmit off), the count register reads NUM_DESC/2, and tx_start_o and irq_o are low.
- R2: Register map by byte address: mode at 0x000 (bit 1 = transmit enable), interrupt source at 0x004, interrupt mask at 0x008 (bits 6:0), transmit count at 0x010. Descriptor i has its status word at 0x400+8*i and its pointer word at 0x404+8*i. Table words read back as written.
- R3: A write to the count register of a value above NUM_DESC stores NUM_DESC. Smaller values are stored unchanged.
- R4: When transmit is enabled and the current descriptor's status bit 15 (ready) is set, tx_start_o pulses for exactly one cycle. The pulse carries tx_ptr_o = pointer word, tx_len_o = status bits 31:16, tx_pad_o = bit 12 and tx_crc_o = bit 11. These outputs stay stable until tx_done_i.
- R5: On tx_done_i the status word is rewritten with bit 15 cleared, bits 8:0 replaced by tx_status_i, and all other bits kept.
- R6: A descriptor whose ready bit is clear stalls the sequencer at that index. No later descriptor is started until software sets the bit.
- R7: After a descriptor with status bit 13 (wrap) set, or after entry count-1, the next descriptor examined is entry 0.
- R8: On completion, interrupt source bit 1 is set when any of tx_status_i bits 3:0 or bit 8 is 1. Otherwise source bit 0 is set if status bit 14 (interrupt request) was set.
- R9: Writing 1 to an interrupt source bit clears it. Writing 0 leaves it unchanged.
- R10: irq_o is high exactly when some interrupt source bit and its matching mask bit are both 1.
- R11: Clearing the transmit enable lets the frame in flight complete and write back. No further frame starts, and on re-enable processing resumes at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 11 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| tx_start_o | output | 1 | One-cycle frame start pulse |
| tx_ptr_o | output | 32 | Buffer pointer of the frame |
| tx_len_o | output | 16 | Frame length |
| tx_pad_o | output | 1 | Pad short frame |
| tx_crc_o | output | 1 | Append CRC |
| tx_done_i | input | 1 | Transmit engine completion strobe |
| tx_status_i | input | 9 | Completion status, written to status bits 8:0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a transmit disable that lands while a frame is in flight. This has to be followed by proof that the index went back to 0 rather than on to the next ready entry. The bench slows the engine stub so the done strobe comes several cycles after the start. It clears the enable inside that window, leaving the following descriptor ready. It then re-enables and requires the scoreboard to see entry 0 first. Wrap-bit handling is reached in a similar way: a ready descriptor is placed right after one with the wrap bit set, and the bench checks that it stays untouched.

// File: rtl/tx_desc_seq_pkg.sv
package tx_desc_seq_pkg;
  localparam int unsigned ADDR_W = 11;
  localparam int unsigned SRC_W  = 7;
  localparam int unsigned STS_W  = 9;

  localparam logic [ADDR_W-1:0] REG_MODE  = 11'h000;
  localparam logic [ADDR_W-1:0] REG_SRC   = 11'h004;
  localparam logic [ADDR_W-1:0] REG_MASK  = 11'h008;
  localparam logic [ADDR_W-1:0] REG_COUNT = 11'h010;
  localparam int unsigned TABLE_BIT = 10;

  localparam int unsigned MODE_TXEN = 1;
  localparam int unsigned ST_READY  = 15;
  localparam int unsigned ST_IRQ    = 14;
  localparam int unsigned ST_WRAP   = 13;
  localparam int unsigned ST_PAD    = 12;
  localparam int unsigned ST_CRC    = 11;

  localparam int unsigned SRC_TXOK  = 0;
  localparam int unsigned SRC_TXERR = 1;

  typedef enum logic [1:0] {SQ_IDLE, SQ_START, SQ_BUSY} sq_state_e;
endpackage

// File: rtl/tx_desc_ram.sv
module tx_desc_ram #(
  parameter int unsigned WORDS = 256,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          sw_we_i,
  input  logic [AW-1:0] sw_addr_i,
  input  logic [31:0]   sw_wdata_i,
  input  logic          hw_we_i,
  input  logic [AW-1:0] hw_addr_i,
  input  logic [31:0]   hw_wdata_i,
  input  logic [AW-1:0] rd_a_addr_i,
  output logic [31:0]   rd_a_o,
  input  logic [AW-1:0] rd_b_addr_i,
  output logic [31:0]   rd_b_o,
  input  logic [AW-1:0] rd_c_addr_i,
  output logic [31:0]   rd_c_o
);
  logic [31:0] mem_q [WORDS];

  // hardware write-back is ordered last and wins a same-word collision
  always_ff @(posedge clk_i) begin
    if (sw_we_i) mem_q[sw_addr_i] <= sw_wdata_i;
    if (hw_we_i) mem_q[hw_addr_i] <= hw_wdata_i;
  end

  assign rd_a_o = mem_q[rd_a_addr_i];
  assign rd_b_o = mem_q[rd_b_addr_i];
  assign rd_c_o = mem_q[rd_c_addr_i];
endmodule

// File: rtl/tx_irq_unit.sv
module tx_irq_unit
  import tx_desc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] set_i,
  input  logic [SRC_W-1:0] clr_i,
  input  logic             mask_we_i,
  input  logic [SRC_W-1:0] mask_wdata_i,
  output logic [SRC_W-1:0] src_o,
  output logic [SRC_W-1:0] mask_o,
  output logic             irq_o
);
  logic [SRC_W-1:0] src_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      mask_q <= '0;
    end else begin
      src_q <= (src_q & ~clr_i) | set_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign src_o  = src_q;
  assign mask_o = mask_q;
  assign irq_o  = |(src_q & mask_q);
endmodule

// File: rtl/tx_seq_fsm.sv
module tx_seq_fsm
  import tx_desc_seq_pkg::*;
#(
  parameter int unsigned NUM_DESC = 128,
  localparam int unsigned IDX_W = $clog2(NUM_DESC),
  localparam int unsigned CNT_W = $clog2(NUM_DESC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [IDX_W-1:0] idx_o,
  input  logic [31:0]      stat_i,
  input  logic [31:0]      ptr_i,
  output logic             tx_start_o,
  output logic [31:0]      tx_ptr_o,
  output logic [15:0]      tx_len_o,
  output logic             tx_pad_o,
  output logic             tx_crc_o,
  input  logic             tx_done_i,
  input  logic [STS_W-1:0] tx_status_i,
  output logic             wb_we_o,
  output logic [31:0]      wb_data_o,
  output logic [SRC_W-1:0] set_o
);
  sq_state_e        state_q;
  logic [IDX_W-1:0] idx_q, idx_next;
  logic [31:0]      stat_q, ptr_q;
  logic             at_last, in_range, err;

  assign at_last  = ({1'b0, idx_q} == count_i - CNT_W'(1));
  assign in_range = ({1'b0, idx_q} < count_i);
  assign idx_next = (stat_q[ST_WRAP] || at_last) ? '0 : idx_q + IDX_W'(1);
  assign err      = (|tx_status_i[3:0]) | tx_status_i[8];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      stat_q  <= '0;
      ptr_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (!en_i || !in_range) idx_q <= '0;
          else if (stat_i[ST_READY]) begin
            stat_q  <= stat_i;
            ptr_q   <= ptr_i;
            state_q <= SQ_START;
          end
        end
        SQ_START: state_q <= SQ_BUSY;
        SQ_BUSY: begin
          if (tx_done_i) begin
            idx_q   <= idx_next;
            state_q <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign idx_o      = idx_q;
  assign tx_start_o = (state_q == SQ_START);
  assign tx_ptr_o   = ptr_q;
  assign tx_len_o   = stat_q[31:16];
  assign tx_pad_o   = stat_q[ST_PAD];
  assign tx_crc_o   = stat_q[ST_CRC];

  assign wb_we_o   = (state_q == SQ_BUSY) && tx_done_i;
  assign wb_data_o = {stat_q[31:16], 1'b0, stat_q[14:STS_W], tx_status_i};

  always_comb begin
    set_o = '0;
    if (wb_we_o) begin
      set_o[SRC_TXERR] = err;
      set_o[SRC_TXOK]  = !err && stat_q[ST_IRQ];
    end
  end
endmodule

// File: rtl/tx_desc_seq.sv
module tx_desc_seq
  import tx_desc_seq_pkg::*;
#(
  parameter int unsigned NUM_DESC = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              tx_start_o,
  output logic [31:0]       tx_ptr_o,
  output logic [15:0]       tx_len_o,
  output logic              tx_pad_o,
  output logic              tx_crc_o,
  input  logic              tx_done_i,
  input  logic [STS_W-1:0]  tx_status_i,
  output logic              irq_o
);
  localparam int unsigned IDX_W = $clog2(NUM_DESC);
  localparam int unsigned CNT_W = $clog2(NUM_DESC + 1);
  localparam int unsigned WORDS = 2 * NUM_DESC;
  localparam int unsigned AW    = $clog2(WORDS);

  logic             tx_en_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SRC_W-1:0] src_q, mask_q, src_set, src_clr;
  logic [IDX_W-1:0] idx;
  logic [31:0]      stat_rd, ptr_rd, tbl_rd, wb_data;
  logic             wb_we, tbl_sel;

  assign tbl_sel = reg_addr_i[TABLE_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      cnt_q   <= CNT_W'(NUM_DESC / 2);
    end else if (reg_wr_i && !tbl_sel) begin
      if (reg_addr_i == REG_MODE) tx_en_q <= reg_wdata_i[MODE_TXEN];
      if (reg_addr_i == REG_COUNT)
        cnt_q <= (reg_wdata_i > 32'(NUM_DESC)) ? CNT_W'(NUM_DESC)
                                                : reg_wdata_i[CNT_W-1:0];
    end
  end

  assign src_clr = (reg_wr_i && !tbl_sel && reg_addr_i == REG_SRC)
                 ? reg_wdata_i[SRC_W-1:0] : '0;

  tx_desc_ram #(.WORDS(WORDS)) u_ram (
    .clk_i       (clk_i),
    .sw_we_i     (reg_wr_i && tbl_sel),
    .sw_addr_i   (reg_addr_i[AW+1:2]),
    .sw_wdata_i  (reg_wdata_i),
    .hw_we_i     (wb_we),
    .hw_addr_i   ({idx, 1'b0}),
    .hw_wdata_i  (wb_data),
    .rd_a_addr_i ({idx, 1'b0}),
    .rd_a_o      (stat_rd),
    .rd_b_addr_i ({idx, 1'b1}),
    .rd_b_o      (ptr_rd),
    .rd_c_addr_i (reg_addr_i[AW+1:2]),
    .rd_c_o      (tbl_rd)
  );

  tx_seq_fsm #(.NUM_DESC(NUM_DESC)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (tx_en_q),
    .count_i     (cnt_q),
    .idx_o       (idx),
    .stat_i      (stat_rd),
    .ptr_i       (ptr_rd),
    .tx_start_o  (tx_start_o),
    .tx_ptr_o    (tx_ptr_o),
    .tx_len_o    (tx_len_o),
    .tx_pad_o    (tx_pad_o),
    .tx_crc_o    (tx_crc_o),
    .tx_done_i   (tx_done_i),
    .tx_status_i (tx_status_i),
    .wb_we_o     (wb_we),
    .wb_data_o   (wb_data),
    .set_o       (src_set)
  );

  tx_irq_unit u_irq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (src_set),
    .clr_i        (src_clr),
    .mask_we_i    (reg_wr_i && !tbl_sel && reg_addr_i == REG_MASK),
    .mask_wdata_i (reg_wdata_i[SRC_W-1:0]),
    .src_o        (src_q),
    .mask_o       (mask_q),
    .irq_o        (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (tbl_sel) reg_rdata_o = tbl_rd;
    else begin
      unique case (reg_addr_i)
        REG_MODE:  reg_rdata_o[MODE_TXEN] = tx_en_q;
        REG_SRC:   reg_rdata_o[SRC_W-1:0] = src_q;
        REG_MASK:  reg_rdata_o[SRC_W-1:0] = mask_q;
        REG_COUNT: reg_rdata_o[CNT_W-1:0] = cnt_q;
        default:   reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tx_desc_seq_chk.sv
module tx_desc_seq_chk
  import tx_desc_seq_pkg::*;
#(
  parameter int unsigned NUM_DESC = 128,
  localparam int unsigned CNT_W = $clog2(NUM_DESC + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [31:0]       reg_wdata_i,
  input logic              tx_start_o,
  input logic [31:0]       tx_ptr_o,
  input logic [15:0]       tx_len_o,
  input logic              tx_done_i,
  input logic [STS_W-1:0]  tx_status_i,
  input logic              tx_en_i,
  input logic [SRC_W-1:0]  src_i,
  input logic [CNT_W-1:0]  cnt_i
);
  logic open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) open_q <= 1'b0;
    else if (tx_start_o) open_q <= 1'b1;
    else if (tx_done_i) open_q <= 1'b0;
  end

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |=> !tx_start_o); // R4
  AST_FRAME_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q && !tx_done_i |=> $stable(tx_ptr_o) && $stable(tx_len_o)); // R4
  AST_START_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(tx_en_i)); // R11
  AST_COUNT_CLAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_i) <= NUM_DESC); // R3
  AST_ERR_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_q && tx_done_i && ((|tx_status_i[3:0]) || tx_status_i[8]) |=> src_i[SRC_TXERR]); // R8
  AST_SRC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_i && reg_addr_i == REG_SRC && reg_wdata_i[SRC_TXOK] && !(open_q && tx_done_i)
    |=> !src_i[SRC_TXOK]); // R9
endmodule

bind tx_desc_seq tx_desc_seq_chk #(.NUM_DESC(NUM_DESC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .tx_start_o  (tx_start_o),
  .tx_ptr_o    (tx_ptr_o),
  .tx_len_o    (tx_len_o),
  .tx_done_i   (tx_done_i),
  .tx_status_i (tx_status_i),
  .tx_en_i     (tx_en_q),
  .src_i       (src_q),
  .cnt_i       (cnt_q)
);

// File: tb/tx_desc_seq_test.sv
`timescale 1ns/1ps
module tx_desc_seq_test;
  localparam int unsigned NUM_DESC = 128;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [10:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tx_start_o, tx_pad_o, tx_crc_o, irq_o;
  logic [31:0] tx_ptr_o;
  logic [15:0] tx_len_o;
  logic        tx_done_i = 1'b0;
  logic [8:0]  tx_status_i = '0;

  tx_desc_seq #(.NUM_DESC(NUM_DESC)) uut (.*);

  always #5 clk_i = ~clk_i;

  typedef struct packed {
    logic [31:0] ptr;
    logic [15:0] len;
    logic        pad;
    logic        crc;
    logic [8:0]  sts;
  } frame_t;

  frame_t exp_q[$];
  int errors = 0, checks = 0, frames = 0, eng_delay = 3;
  bit busy = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_stat(input logic [15:0] len, input bit rdy, input bit irq,
                                          input bit wrap, input bit pad, input bit crc,
                                          input logic [8:0] sts);
    return {len, rdy, irq, wrap, pad, crc, 2'b00, sts};
  endfunction

  task automatic reg_write(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_read(input logic [10:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic expect_frame(input logic [31:0] ptr, input logic [15:0] len, input bit pad,
                              input bit crc, input logic [8:0] sts);
    exp_q.push_back({ptr, len, pad, crc, sts});
  endtask

  task automatic drain();
    for (int i = 0; i < 500; i++) begin
      @(negedge clk_i);
      if (exp_q.size() == 0 && !busy) break;
    end
    repeat (3) @(negedge clk_i);
  endtask

  task automatic chk_reg(input logic [10:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    reg_read(a, d);
    check(d == exp, req, d, exp);
  endtask

  // scoreboard monitor and transmit engine stub
  initial begin
    forever begin
      @(negedge clk_i);
      if (tx_start_o) begin
        frame_t e;
        busy = 1;
        if (exp_q.size() == 0) begin
          check(0, "R6/R7/R11 unexpected start", tx_ptr_o, 32'h0);
          e = '0;
        end else begin
          e = exp_q.pop_front();
          check(tx_ptr_o == e.ptr && tx_len_o == e.len && tx_pad_o == e.pad && tx_crc_o == e.crc,
                "R4 frame fields", {tx_len_o, 14'b0, tx_pad_o, tx_crc_o}, {e.len, 14'b0, e.pad, e.crc});
          check(tx_ptr_o == e.ptr, "R4 pointer", tx_ptr_o, e.ptr);
        end
        @(negedge clk_i);
        check(!tx_start_o, "R4 start one cycle", 32'(tx_start_o), 32'h0);
        repeat (eng_delay - 1) @(negedge clk_i);
        tx_status_i = e.sts; tx_done_i = 1'b1;
        @(negedge clk_i);
        tx_done_i = 1'b0; tx_status_i = '0;
        frames++;
        busy = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [10:0] M = 11'h000, S = 11'h004, K = 11'h008, C = 11'h010;
  function automatic logic [10:0] sa(input int i); return 11'(32'h400 + 8 * i); endfunction
  function automatic logic [10:0] pa(input int i); return 11'(32'h404 + 8 * i); endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    chk_reg(S, 32'h0, "R1 source");
    chk_reg(K, 32'h0, "R1 mask");
    chk_reg(M, 32'h0, "R1 mode");
    chk_reg(C, NUM_DESC / 2, "R1 count");
    check(!irq_o && !tx_start_o, "R1 outputs", {30'b0, irq_o, tx_start_o}, 32'h0);

    // R3 clamp, R2 table readback
    reg_write(C, 200);
    chk_reg(C, NUM_DESC, "R3 clamp");
    reg_write(C, 4);
    chk_reg(C, 4, "R3 small count");
    reg_write(pa(5), 32'hDEAD_BEEF);
    chk_reg(pa(5), 32'hDEAD_BEEF, "R2 table word");

    // basic ring: two ready, one stalls
    for (int i = 0; i < 4; i++) reg_write(pa(i), 32'h0001_0000 + 32'h600 * i);
    reg_write(sa(2), mk_stat(60, 0, 0, 0, 0, 1, 0));
    reg_write(sa(3), mk_stat(50, 0, 0, 0, 0, 1, 0));
    expect_frame(32'h0001_0000, 100, 0, 1, 9'h000);
    expect_frame(32'h0001_0600, 40, 1, 1, 9'h030);
    reg_write(sa(0), mk_stat(100, 1, 1, 0, 0, 1, 9'h1FF));
    reg_write(sa(1), mk_stat(40, 1, 0, 0, 1, 1, 0));
    reg_write(M, 32'h2);
    drain();
    chk_reg(sa(0), mk_stat(100, 0, 1, 0, 0, 1, 9'h000), "R5 writeback d0");
    chk_reg(sa(1), mk_stat(40, 0, 0, 0, 1, 1, 9'h030), "R5 writeback d1");
    chk_reg(S, 32'h1, "R8 irq-request source");
    check(!irq_o, "R10 masked", 32'(irq_o), 32'h0);

    // R6 stall on not-ready entry
    repeat (20) @(negedge clk_i);
    check(frames == 2, "R6 stall", frames, 2);
    chk_reg(sa(2), mk_stat(60, 0, 0, 0, 0, 1, 0), "R6 untouched");
    expect_frame(32'h0001_0C00, 60, 0, 1, 9'h004);
    reg_write(sa(2), mk_stat(60, 1, 0, 0, 0, 1, 0));
    drain();
    chk_reg(S, 32'h3, "R8 error source");
    chk_reg(sa(2), mk_stat(60, 0, 0, 0, 0, 1, 9'h004), "R5 error writeback");

    // R7: last entry wraps by count, wrap bit returns to 0
    reg_write(sa(1), mk_stat(70, 1, 0, 0, 0, 1, 0));
    reg_write(sa(0), mk_stat(64, 1, 0, 1, 0, 1, 0));
    expect_frame(32'h0001_1200, 50, 0, 1, 9'h000);
    expect_frame(32'h0001_0000, 64, 0, 1, 9'h000);
    reg_write(sa(3), mk_stat(50, 1, 0, 0, 0, 1, 0));
    drain();
    repeat (20) @(negedge clk_i);
    check(frames == 5, "R7 wrap order", frames, 5);
    chk_reg(sa(1), mk_stat(70, 1, 0, 0, 0, 1, 0), "R7 entry after wrap untouched");
    reg_write(sa(1), mk_stat(70, 0, 0, 0, 0, 1, 0));

    // R10 mask, R9 write-1-clear
    reg_write(K, 32'h1);
    check(irq_o, "R10 mask bit0", 32'(irq_o), 32'h1);
    reg_write(K, 32'h0);
    check(!irq_o, "R10 mask off", 32'(irq_o), 32'h0);
    reg_write(K, 32'h2);
    reg_write(S, 32'h2);
    chk_reg(S, 32'h1, "R9 clear bit1");
    check(!irq_o, "R10 after clear", 32'(irq_o), 32'h0);
    reg_write(S, 32'h0);
    chk_reg(S, 32'h1, "R9 write zero");
    reg_write(S, 32'h1);
    chk_reg(S, 32'h0, "R9 clear bit0");

    // R11 disable during flight
    reg_write(M, 32'h0);
    eng_delay = 8;
    reg_write(sa(1), mk_stat(90, 1, 0, 0, 0, 0, 0));
    expect_frame(32'h0001_0000, 80, 0, 1, 9'h000);
    reg_write(sa(0), mk_stat(80, 1, 0, 0, 0, 1, 0));
    reg_write(M, 32'h2);
    wait (busy);
    reg_write(M, 32'h0);
    drain();
    repeat (20) @(negedge clk_i);
    check(frames == 6, "R11 no start when disabled", frames, 6);
    chk_reg(sa(0), mk_stat(80, 0, 0, 0, 0, 1, 0), "R11 in-flight writeback");
    chk_reg(sa(1), mk_stat(90, 1, 0, 0, 0, 0, 0), "R11 next untouched");
    eng_delay = 3;
    expect_frame(32'h0001_0000, 81, 0, 1, 9'h000);
    expect_frame(32'h0001_0600, 90, 0, 0, 9'h000);
    reg_write(sa(0), mk_stat(81, 1, 0, 0, 0, 1, 0));
    reg_write(M, 32'h2);
    drain();
    check(frames == 8, "R11 resume at entry 0", frames, 8);
    check(exp_q.size() == 0, "R4 scoreboard empty", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule